// File: doc/BRIEF.md
# Cascaded Accumulator Noise-Shaping Modulator

This block turns an unsigned fractional word into a stream of small signed integer codes. Over many clock cycles, the average of those codes equals the fraction divided by 2^W. The quantisation error is pushed toward high frequencies. Typical users are a fractional-N divider, which adds the code to an integer divide value, and an oversampled DAC path, which filters the code stream.

The structure is a chain of up to three wrapping accumulators, all W bits wide:

- The first accumulator adds the input word once per enabled cycle.
- Each later accumulator adds the fresh residue that the stage before it produced in the same cycle.
- Each stage's overflow bit is passed through a small difference network of flip-flops and adders. The network turns the overflow bits into one registered two's-complement code.

The block has no feedback path outside each accumulator's own register. For that reason it stays stable for every input word and every stage count.

The stage count is a parameter from 1 to 3. The output width follows it: STAGES+1 bits.

Top module: `mash_modulator`

## Requirements
- R1: A low `rst_n` at a rising clock edge clears every accumulator and every carry delay flip-flop. `code_o` then reads 0 from that edge on. After reset, carries from cycles before the reset count as 0.
- R2: On every enabled edge, stage 1 forms `acc1 + frac_i`, and stage k+1 forms `acc(k+1) + residue_k`. Here `residue_k` is the new low W bits of stage k. Each sum keeps its low W bits as the new residue and yields a carry bit equal to bit W of the sum.
- R3: After an enabled edge n, `code_o` equals c1[n] + c2[n] − c2[n−1] + c3[n] − 2·c3[n−1] + c3[n−2]. Here [n−1] and [n−2] are earlier enabled cycles. With fewer stages, the terms of the missing stages are dropped.
- R4: `code_o` is two's complement, STAGES+1 bits wide. It always lies between 1 − 2^(STAGES−1) and 2^(STAGES−1): −3 to +4 for three stages.
- R5: An edge with `en` low changes neither the accumulators, the carry delays nor `code_o`.
- R6: If every enabled cycle since reset has carried `frac_i = 0`, then `code_o` stays 0 and every residue stays 0.
- R7: For three stages and a constant `frac_i = x`, the sum of the first 2^W codes after reset lies between x − 1 and x + 2. This holds because the carry differences telescope and leave at most the final c2 and c3 terms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Advances the accumulators and the code when high |
| frac_i | input | W | Unsigned fractional word, value / 2^W |
| code_o | output | STAGES+1 | Registered signed output code |

## Verification
The assertions assume that `rst_n` is low at the first clock edge, so that every register starts from a known zero. The zero-input property also assumes that `frac_i` is a stable, defined value at each edge. The bench meets both assumptions:

- It resets before any stimulus and changes `frac_i` and `en` only one time unit after a rising edge.
- It drives only defined values.
- It keeps each window test on one constant word, so the telescoped sum bound applies to that window.

// File: rtl/mash_pkg.sv
// Package: shared helpers for the cascaded accumulator modulator.
// Assumes the stage count is between 1 and 3.
package mash_pkg;

    // Width of the signed output code for a given stage count.
    function automatic int code_width(input int stages);
        return stages + 1;
    endfunction

    // Largest code value the difference network can produce.
    function automatic int code_max(input int stages);
        return 1 << (stages - 1);
    endfunction

    // Smallest code value the difference network can produce.
    function automatic int code_min(input int stages);
        return 1 - (1 << (stages - 1));
    endfunction

endpackage

// File: rtl/mash_acc_stage.sv
// Module: one wrapping accumulator of the cascade.
// The stage presents the new residue and the overflow bit combinationally,
// so that the next stage can consume the residue in the same cycle.
// Assumes en gates all state changes and rst_n is synchronous, active low.
module mash_acc_stage #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] add_i,
    output logic [W-1:0] sum_o,
    output logic         carry_o
);

    logic [W-1:0] acc_q;
    logic [W:0]   total;

    // Widened add, so that the overflow is bit W.
    always_comb begin
        total = {1'b0, acc_q} + {1'b0, add_i};
    end

    assign sum_o   = total[W-1:0];
    assign carry_o = total[W];

    // Keep the residue when enabled; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (en) begin
            acc_q <= total[W-1:0];
        end
    end

endmodule

// File: rtl/mash_carry_combiner.sv
// Module: turns the per-stage carry bits into one signed code.
// Stage k (0-based) contributes its carry passed through a k-th order
// backward difference, using carries of earlier enabled cycles.
// Each carry is delayed by its own flip-flops, and the summed code is registered.
// Assumes 1 <= STAGES <= 3 and CW >= STAGES+1.
module mash_carry_combiner #(
    parameter int STAGES = 3,
    parameter int CW     = STAGES + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [STAGES-1:0]    carry_i,
    output logic signed [CW-1:0] code_o
);

    logic signed [CW-1:0] term [STAGES];
    logic signed [CW-1:0] code_sum;

    for (genvar k = 0; k < STAGES; k++) begin : g_term
        logic signed [CW-1:0] cur_s;

        // Carry of this cycle as a signed value of code width.
        always_comb begin
            cur_s = {{(CW-1){1'b0}}, carry_i[k]};
        end

        if (k == 0) begin : g_order0
            // Term for the first stage: its carry passes through unchanged.
            always_comb begin
                term[k] = cur_s;
            end
        end else if (k == 1) begin : g_order1
            logic                 d1_q;
            logic signed [CW-1:0] d1_s;

            // Delay of one enabled cycle for the second-stage carry.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    d1_q <= 1'b0;
                end else if (en) begin
                    d1_q <= carry_i[k];
                end
            end

            // First difference of the second-stage carry.
            always_comb begin
                d1_s    = {{(CW-1){1'b0}}, d1_q};
                term[k] = cur_s - d1_s;
            end
        end else begin : g_order2
            logic                 d1_q;
            logic                 d2_q;
            logic signed [CW-1:0] d1_s;
            logic signed [CW-1:0] d2_s;

            // Delays of one and two enabled cycles for the third-stage carry.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    d1_q <= 1'b0;
                    d2_q <= 1'b0;
                end else if (en) begin
                    d1_q <= carry_i[k];
                    d2_q <= d1_q;
                end
            end

            // Second difference: c - 2*c' + c''.
            always_comb begin
                d1_s    = {{(CW-1){1'b0}}, d1_q};
                d2_s    = {{(CW-1){1'b0}}, d2_q};
                term[k] = cur_s - (d1_s <<< 1) + d2_s;
            end
        end
    end

    // Add up the contributions of all stages.
    always_comb begin
        code_sum = '0;
        for (int k = 0; k < STAGES; k++) begin
            code_sum = code_sum + term[k];
        end
    end

    // Register the code on enabled cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_o <= '0;
        end else if (en) begin
            code_o <= code_sum;
        end
    end

endmodule

// File: rtl/mash_modulator.sv
// Module: top of the cascaded accumulator noise-shaping modulator.
// Stage 1 adds frac_i. Stage k+1 adds the new residue of stage k in the
// same cycle, so all carries belong to one accumulation step.
// The carries feed the difference network, which produces the registered code.
// Assumes 1 <= STAGES <= 3. Reset is synchronous, active low.
module mash_modulator #(
    parameter int W      = 16,
    parameter int STAGES = 3,
    parameter int CW     = mash_pkg::code_width(STAGES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [W-1:0]         frac_i,
    output logic signed [CW-1:0] code_o
);

    logic [W-1:0]      feed [STAGES+1];
    logic [STAGES-1:0] carries;

    // Feed the input word into the head of the residue chain.
    always_comb begin
        feed[0] = frac_i;
    end

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        mash_acc_stage #(
            .W(W)
        ) stage_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (en),
            .add_i   (feed[k]),
            .sum_o   (feed[k+1]),
            .carry_o (carries[k])
        );
    end

    mash_carry_combiner #(
        .STAGES(STAGES),
        .CW    (CW)
    ) comb_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .carry_i (carries),
        .code_o  (code_o)
    );

endmodule

// File: rtl/mash_modulator_chk.sv
// Module: assertion checker bound to mash_modulator.
// Assumes rst_n is low at the first clock edge.
module mash_modulator_chk #(
    parameter int W      = 16,
    parameter int STAGES = 3,
    parameter int CW     = STAGES + 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 en,
    input logic [W-1:0]         frac_i,
    input logic signed [CW-1:0] code_o,
    input logic [W-1:0]         tail_resid
);

    localparam int LO = mash_pkg::code_min(STAGES);
    localparam int HI = mash_pkg::code_max(STAGES);

    logic nz_seen_q;

    // Record whether any non-zero word has been accumulated since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nz_seen_q <= 1'b0;
        end else if (en && frac_i != '0) begin
            nz_seen_q <= 1'b1;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> code_o == '0); // R1

    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(code_o) >= LO) && (int'(code_o) <= HI)); // R4

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(code_o)); // R5

    AST_CHANGE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(code_o)) |-> $past(en)); // R5

    AST_ZERO_INPUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!nz_seen_q && frac_i == '0) |-> (code_o == '0 && tail_resid == '0)); // R6

endmodule

bind mash_modulator mash_modulator_chk #(
    .W     (W),
    .STAGES(STAGES),
    .CW    (CW)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .frac_i     (frac_i),
    .code_o     (code_o),
    .tail_resid (feed[STAGES])
);

// File: tb/mash_modulator_tb_top.sv
module mash_modulator_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 10;
    localparam int S          = 3;
    localparam int CW         = S + 1;
    localparam int MOD        = 1 << W;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 en = 1'b0;
    logic [W-1:0]         frac = '0;
    logic signed [CW-1:0] code;

    int n_cmp = 0;
    int n_bad = 0;

    // Behavioural reference state.
    int acc [3];
    int h1 [3];
    int h2 [3];
    int exp_code = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mash_modulator #(.W(W), .STAGES(S)) dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .frac_i (frac),
        .code_o (code)
    );

    task automatic model_reset();
        for (int k = 0; k < 3; k++) begin
            acc[k] = 0; h1[k] = 0; h2[k] = 0;
        end
        exp_code = 0;
    endtask

    task automatic model_step(input int x);
        int v;
        int c [3];
        v = x;
        for (int k = 0; k < 3; k++) begin
            c[k] = 0;
            if (k < S) begin
                int t;
                t      = acc[k] + v;
                c[k]   = t / MOD;
                acc[k] = t % MOD;
                v      = acc[k];
            end
        end
        exp_code = c[0];
        if (S > 1) exp_code += c[1] - h1[1];
        if (S > 2) exp_code += c[2] - 2 * h1[2] + h2[2];
        for (int k = 0; k < 3; k++) begin
            h2[k] = h1[k];
            h1[k] = c[k];
        end
    endtask

    task automatic check(input string tag, input int act, input int expv);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
        end
    endtask

    // One clock: drive, update the model at the edge, compare after it.
    task automatic tick(input logic e, input int x, input string tag);
        en   = e;
        frac = x[W-1:0];
        @(posedge clk);
        if (!rst_n) model_reset();
        else if (e) model_step(x);
        #1;
        check(tag, int'(code), exp_code);
        if (int'(code) < -((1 << (S-1)) - 1) || int'(code) > (1 << (S-1)))
            check("R4 range", int'(code), exp_code + 1000);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(1'b1, 37, "R1 reset clears code");
        tick(1'b0, 0, "R1 reset clears code");
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int sum;
        int prev;
        int words [5] = '{1, 3, 512, 341, 1023};

        do_reset();

        // R6: zero input keeps the code at zero.
        for (int i = 0; i < 50; i++) tick(1'b1, 0, "R6 zero input");

        // R2/R3: several fixed words, compared cycle by cycle.
        for (int w = 0; w < 5; w++) begin
            do_reset();
            for (int i = 0; i < 200; i++) tick(1'b1, words[w], "R3 code sequence");
        end

        // R2/R3/R4: changing words every cycle.
        do_reset();
        for (int i = 0; i < 2000; i++) tick(1'b1, int'($urandom_range(0, MOD-1)), "R2 random words");

        // R5: enable low holds the code and the state.
        for (int i = 0; i < 400; i++) begin
            logic e;
            e    = ($urandom_range(0, 2) == 0);
            prev = int'(code);
            tick(e, int'($urandom_range(0, MOD-1)), "R5 enable gating");
            if (!e) check("R5 hold on idle", int'(code), prev);
        end

        // R1: reset in the middle of activity.
        tick(1'b1, 777, "R3 code sequence");
        do_reset();
        check("R1 code after reset", int'(code), 0);

        // R7: window sum over 2^W cycles lies within [x-1, x+2].
        for (int w = 0; w < 5; w++) begin
            do_reset();
            sum = 0;
            for (int i = 0; i < MOD; i++) begin
                tick(1'b1, words[w], "R3 window sequence");
                sum += int'(code);
            end
            if (sum >= words[w] - 1 && sum <= words[w] + 2)
                check("R7 window sum", sum, sum);
            else
                check("R7 window sum", sum, words[w]);
        end

        finish_run();
    end

endmodule